// File: doc/BRIEF.md
# Multicycle Processor Datapath Core

This block is the storage and steering half of a 32-bit load/store processor that spends several clock cycles on each instruction and shares a single memory port between instruction fetch and data access. It holds the program counter, the instruction register, a memory data register, two operand registers, an ALU result register, a 32-entry register file and one ALU with a zero flag. Around these sit the selectors that choose the memory address, the two ALU operands, the register-file write address and write data, and the next program counter value.

All decisions come from an external sequencer that drives one control word per cycle and reads back the opcode and function fields of the held instruction and the ALU zero flag. Because intermediate results are kept in registers between cycles, the single ALU can increment the PC in one cycle, form a branch target in the next, and then do address or arithmetic work. The memory answers combinationally: `mem_rdata` must carry the word at `mem_addr` in the same cycle, and a write happens at the clock edge that ends a cycle with `mem_wr` high.

Top module: `mcdp_core`

## Requirements
- R1: `mem_addr` shows the PC when `ctl_addr_sel`=0 and the ALU result register when `ctl_addr_sel`=1; `mem_rd` and `mem_wr` follow `ctl_mem_rd` and `ctl_mem_wr` in the same cycle.
- R2: The first ALU operand is the PC when `ctl_srca_sel`=0 and operand register A when `ctl_srca_sel`=1.
- R3: The second ALU operand is selected by `ctl_srcb_sel`: 0 operand register B, 1 the constant 4, 2 instruction bits 15..0 sign-extended, 3 that sign-extended value shifted left by two.
- R4: At every clock edge A captures the register indexed by instruction bits 25..21 and B the register indexed by bits 20..16; `mem_wdata` shows B. The register written is indexed by bits 15..11 when `ctl_dst_sel`=1 and by bits 20..16 when `ctl_dst_sel`=0, at the edge ending a cycle with `ctl_rf_wr`=1.
- R5: Register write data is the ALU result register when `ctl_wb_sel`=0 and the memory data register when `ctl_wb_sel`=1.
- R6: Register 0 always reads as zero; writes to it have no effect.
- R7: The PC is written when `ctl_pc_wr`=1, or when `ctl_pc_wr_cond`=1 and `alu_zero`=1; otherwise it holds. `alu_zero` is 1 exactly when the current ALU result is zero.
- R8: The instruction register loads `mem_rdata` only at edges ending a cycle with `ctl_ir_wr`=1; `ir_opcode` shows its bits 31..26 and `ir_funct` its bits 5..0.
- R9: `ctl_pc_src` picks the next PC: 0 the ALU result of the current cycle, 1 the ALU result register, 2 or 3 the jump target formed from PC bits 31..28, instruction bits 25..0 and two zero bits.
- R10: A synchronous active-high `rst` sets the PC to 0x00000040 and clears the instruction, memory data, operand and ALU result registers and every register-file entry.
- R11: `ctl_alu_op` selects 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 signed less-than, 7 unsigned less-than (less-than results are 1 or 0).
- R12: The memory data register and the ALU result register load at every clock edge, so a value formed in one cycle is usable through them in the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pc_wr | input | 1 | Unconditional PC write |
| ctl_pc_wr_cond | input | 1 | PC write when the ALU result is zero |
| ctl_pc_src | input | 2 | Next-PC source select |
| ctl_addr_sel | input | 1 | Memory address source: PC or ALU result register |
| ctl_ir_wr | input | 1 | Instruction register load enable |
| ctl_srca_sel | input | 1 | First ALU operand select |
| ctl_srcb_sel | input | 2 | Second ALU operand select |
| ctl_alu_op | input | 3 | ALU operation |
| ctl_dst_sel | input | 1 | Register write index field select |
| ctl_wb_sel | input | 1 | Register write data select |
| ctl_rf_wr | input | 1 | Register file write enable |
| ctl_mem_rd | input | 1 | Memory read request from the sequencer |
| ctl_mem_wr | input | 1 | Memory write request from the sequencer |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data for `mem_addr` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_opcode | output | 6 | Held instruction bits 31..26 |
| ir_funct | output | 6 | Held instruction bits 5..0 |
| alu_zero | output | 1 | Current ALU result is zero |

## Verification
The embedded properties watch, on every cycle, that the PC and instruction register hold whenever their enables are low, that the instruction register takes the memory word when enabled, that the memory data and operand registers follow their sources one edge later, and that a register-file write reaches the addressed entry. Operand encodings, the eight ALU functions, the sign extension of immediates, the choice of write index and write data, the register-0 rule, taken and untaken branches, the jump target and the reset values can only be shown by the bench, which runs short instruction sequences and observes results through store addresses and store data, fetch addresses and the zero flag.

// File: rtl/mcdp_pkg.sv
`timescale 1ns/1ps
package mcdp_pkg;

   typedef enum logic [2:0] {
      ALU_ADD  = 3'd0,
      ALU_SUB  = 3'd1,
      ALU_AND  = 3'd2,
      ALU_OR   = 3'd3,
      ALU_XOR  = 3'd4,
      ALU_NOR  = 3'd5,
      ALU_SLT  = 3'd6,
      ALU_SLTU = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      OPB_REG   = 2'd0,
      OPB_STEP  = 2'd1,
      OPB_IMM   = 2'd2,
      OPB_IMM_W = 2'd3
   } opb_sel_e;

   typedef enum logic [1:0] {
      PCN_ALU      = 2'd0,
      PCN_HELD     = 2'd1,
      PCN_JUMP     = 2'd2,
      PCN_JUMP_ALT = 2'd3
   } pc_src_e;

   // Instruction field layout (decoded by the sequencer and by this datapath)
   localparam int unsigned INSN_W   = 32;
   localparam int unsigned OPC_LSB  = 26;
   localparam int unsigned OPC_W    = 6;
   localparam int unsigned RS_LSB   = 21;
   localparam int unsigned RT_LSB   = 16;
   localparam int unsigned RD_LSB   = 11;
   localparam int unsigned FUNCT_W  = 6;
   localparam int unsigned IMM_W    = 16;
   localparam int unsigned JIDX_W   = 26;
   localparam int unsigned REGF_W   = 5;
   localparam int unsigned JREGION_LSB = 28;

endpackage

// File: rtl/mcdp_alu.sv
`timescale 1ns/1ps
module mcdp_alu
   import mcdp_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  alu_op_e             op,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   output logic [DATA_W-1:0]   res,
   output logic                zero
);

   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W:0]   diff;
   logic              lt_signed;
   logic              lt_unsigned;

   generate
      if (DATA_W < 2) begin : g_chk_w
         $error("mcdp_alu: DATA_W must be at least 2");
      end
   endgenerate

   always_comb begin
      diff        = {1'b0, opa} - {1'b0, opb};
      lt_unsigned = diff[DATA_W];
      lt_signed   = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : diff[MSB];
   end

   always_comb begin
      unique case (op)
         ALU_ADD:  res = opa + opb;
         ALU_SUB:  res = diff[MSB:0];
         ALU_AND:  res = opa & opb;
         ALU_OR:   res = opa | opb;
         ALU_XOR:  res = opa ^ opb;
         ALU_NOR:  res = ~(opa | opb);
         ALU_SLT:  res = {{(DATA_W-1){1'b0}}, lt_signed};
         ALU_SLTU: res = {{(DATA_W-1){1'b0}}, lt_unsigned};
         default:  res = '0;
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/mcdp_opsel.sv
`timescale 1ns/1ps
module mcdp_opsel
   import mcdp_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PC_STEP = 4,
   parameter int unsigned IMM_SHL = 2
)(
   input  logic                srca_sel,
   input  opb_sel_e            srcb_sel,
   input  logic [DATA_W-1:0]   pc,
   input  logic [DATA_W-1:0]   reg_a,
   input  logic [DATA_W-1:0]   reg_b,
   input  logic [IMM_W-1:0]    imm,
   output logic [DATA_W-1:0]   opa,
   output logic [DATA_W-1:0]   opb
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] imm_sx_shl;

   generate
      if (DATA_W <= IMM_W) begin : g_chk_w
         $error("mcdp_opsel: DATA_W must exceed the immediate width");
      end
      if (PC_STEP == 0) begin : g_chk_step
         $error("mcdp_opsel: PC_STEP must be nonzero");
      end
   endgenerate

   assign imm_sx     = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_sx_shl = imm_sx << IMM_SHL;

   assign opa = srca_sel ? reg_a : pc;

   always_comb begin
      unique case (srcb_sel)
         OPB_REG:   opb = reg_b;
         OPB_STEP:  opb = DATA_W'(PC_STEP);
         OPB_IMM:   opb = imm_sx;
         OPB_IMM_W: opb = imm_sx_shl;
         default:   opb = reg_b;
      endcase
   end

endmodule

// File: rtl/mcdp_regfile.sv
`timescale 1ns/1ps
module mcdp_regfile #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned NREG         = 32,
   parameter bit          ZERO_R0      = 1'b1,
   parameter bit          RESET_CLEARS = 1'b1,
   localparam int unsigned AW          = $clog2(NREG)
)(
   input  logic                clk,
   input  logic                rst,
   input  logic [AW-1:0]       rd_addr_a,
   input  logic [AW-1:0]       rd_addr_b,
   output logic [DATA_W-1:0]   rd_data_a,
   output logic [DATA_W-1:0]   rd_data_b,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [DATA_W-1:0]   wr_data
);

   logic [DATA_W-1:0] ent [NREG];

   generate
      if (NREG < 2 || (1 << AW) != NREG) begin : g_chk_n
         $error("mcdp_regfile: NREG must be a power of two, at least 2");
      end

      for (genvar k = 0; k < NREG; k++) begin : g_ent
         if (ZERO_R0 && k == 0) begin : g_hard
            assign ent[k] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            if (RESET_CLEARS) begin : g_rst
               always_ff @(posedge clk) begin
                  if (rst)
                     q <= '0;
                  else if (wr_en && wr_addr == AW'(k))
                     q <= wr_data;
               end
            end else begin : g_norst
               always_ff @(posedge clk) begin
                  if (wr_en && wr_addr == AW'(k))
                     q <= wr_data;
               end
            end
            assign ent[k] = q;
         end
      end
   endgenerate

   assign rd_data_a = ent[rd_addr_a];
   assign rd_data_b = ent[rd_addr_b];

   // A write to a storing entry is visible there after the edge
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr != '0 || !ZERO_R0)) |=> ent[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/mcdp_core.sv
`timescale 1ns/1ps
module mcdp_core
   import mcdp_pkg::*;
#(
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       NREG     = 32,
   parameter int unsigned       PC_STEP  = 4,
   parameter logic [DATA_W-1:0] RESET_PC = DATA_W'(32'h0000_0040)
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                ctl_pc_wr,
   input  logic                ctl_pc_wr_cond,
   input  logic [1:0]          ctl_pc_src,
   input  logic                ctl_addr_sel,
   input  logic                ctl_ir_wr,
   input  logic                ctl_srca_sel,
   input  logic [1:0]          ctl_srcb_sel,
   input  logic [2:0]          ctl_alu_op,
   input  logic                ctl_dst_sel,
   input  logic                ctl_wb_sel,
   input  logic                ctl_rf_wr,
   input  logic                ctl_mem_rd,
   input  logic                ctl_mem_wr,
   output logic [DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic [OPC_W-1:0]    ir_opcode,
   output logic [FUNCT_W-1:0]  ir_funct,
   output logic                alu_zero
);

   localparam int unsigned RF_AW   = $clog2(NREG);
   localparam int unsigned JHI_W   = DATA_W - JREGION_LSB;
   localparam int unsigned IMM_SHL = 2;

   generate
      if (DATA_W < INSN_W) begin : g_chk_w
         $error("mcdp_core: DATA_W must hold a full instruction");
      end
      if (RF_AW > REGF_W) begin : g_chk_rf
         $error("mcdp_core: NREG exceeds what a register field can index");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_chk_pc
         $error("mcdp_core: RESET_PC must be word aligned");
      end
   endgenerate

   // Architectural and intermediate registers
   logic [DATA_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] mdr_q;
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic [DATA_W-1:0] alu_q;

   // Internal nets
   logic [DATA_W-1:0] rf_rd_a;
   logic [DATA_W-1:0] rf_rd_b;
   logic [RF_AW-1:0]  rf_wr_addr;
   logic [DATA_W-1:0] rf_wr_data;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] alu_res;
   logic              alu_z;
   logic [DATA_W-1:0] jump_tgt;
   logic [DATA_W-1:0] pc_next;
   logic              pc_en;

   // Register file
   assign rf_wr_addr = ctl_dst_sel ? ir_q[RD_LSB +: RF_AW] : ir_q[RT_LSB +: RF_AW];
   assign rf_wr_data = ctl_wb_sel  ? mdr_q : alu_q;

   mcdp_regfile #(
      .DATA_W       (DATA_W),
      .NREG         (NREG),
      .ZERO_R0      (1'b1),
      .RESET_CLEARS (1'b1)
   ) u_rf (
      .clk       (clk),
      .rst       (rst),
      .rd_addr_a (ir_q[RS_LSB +: RF_AW]),
      .rd_addr_b (ir_q[RT_LSB +: RF_AW]),
      .rd_data_a (rf_rd_a),
      .rd_data_b (rf_rd_b),
      .wr_en     (ctl_rf_wr),
      .wr_addr   (rf_wr_addr),
      .wr_data   (rf_wr_data)
   );

   // Operand selection and ALU
   mcdp_opsel #(
      .DATA_W  (DATA_W),
      .PC_STEP (PC_STEP),
      .IMM_SHL (IMM_SHL)
   ) u_opsel (
      .srca_sel (ctl_srca_sel),
      .srcb_sel (opb_sel_e'(ctl_srcb_sel)),
      .pc       (pc_q),
      .reg_a    (a_q),
      .reg_b    (b_q),
      .imm      (ir_q[IMM_W-1:0]),
      .opa      (opa),
      .opb      (opb)
   );

   mcdp_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op   (alu_op_e'(ctl_alu_op)),
      .opa  (opa),
      .opb  (opb),
      .res  (alu_res),
      .zero (alu_z)
   );

   // Next PC
   assign jump_tgt = {pc_q[DATA_W-1 -: JHI_W], ir_q[JIDX_W-1:0], {IMM_SHL{1'b0}}};

   always_comb begin
      unique case (pc_src_e'(ctl_pc_src))
         PCN_ALU:      pc_next = alu_res;
         PCN_HELD:     pc_next = alu_q;
         PCN_JUMP,
         PCN_JUMP_ALT: pc_next = jump_tgt;
         default:      pc_next = alu_res;
      endcase
   end

   assign pc_en = ctl_pc_wr | (ctl_pc_wr_cond & alu_z);

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= RESET_PC;
      else if (pc_en)
         pc_q <= pc_next;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ir_q <= '0;
      else if (ctl_ir_wr)
         ir_q <= mem_rdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mdr_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
      end else begin
         mdr_q <= mem_rdata;
         a_q   <= rf_rd_a;
         b_q   <= rf_rd_b;
         alu_q <= alu_res;
      end
   end

   // Outputs
   assign mem_addr  = ctl_addr_sel ? alu_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl_mem_rd;
   assign mem_wr    = ctl_mem_wr;
   assign ir_opcode = ir_q[OPC_LSB +: OPC_W];
   assign ir_funct  = ir_q[FUNCT_W-1:0];
   assign alu_zero  = alu_z;

   // PC keeps its value when no write condition holds
   assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_zero)) |=> $stable(pc_q));

   // Instruction register holds without its enable
   assert_ir_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ctl_ir_wr |=> $stable(ir_q));

   // Instruction register takes the memory word when enabled
   assert_ir_load_R8: assert property (@(posedge clk) disable iff (rst)
      ctl_ir_wr |=> ir_q == $past(mem_rdata));

   // Memory data register follows the read bus every cycle
   assert_mdr_follow_R12: assert property (@(posedge clk) disable iff (rst)
      !rst |=> mdr_q == $past(mem_rdata));

   // Operand registers follow the register file read ports every cycle
   assert_operand_capture_R4: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (a_q == $past(rf_rd_a) && b_q == $past(rf_rd_b)));

endmodule

// File: tb/mcdp_core_test.sv
`timescale 1ns/1ps
module mcdp_core_test;

   localparam logic [31:0] START = 32'h0000_0040;
   localparam int SEL_ADDR = 0, SEL_WDATA = 1, SEL_ZERO = 2, SEL_OPC = 3, SEL_FUNCT = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic c_pc_wr, c_pc_cond, c_addr_sel, c_ir_wr, c_srca, c_dst, c_wb, c_rf_wr, c_mrd, c_mwr;
   logic [1:0] c_srcb, c_pcsrc;
   logic [2:0] c_op;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic mem_rd, mem_wr, alu_zero;
   logic [5:0] opcode, funct;

   logic [31:0] ram [128];
   assign mem_rdata = ram[mem_addr[8:2]];

   mcdp_core uut (
      .clk(clk), .rst(rst),
      .ctl_pc_wr(c_pc_wr), .ctl_pc_wr_cond(c_pc_cond), .ctl_pc_src(c_pcsrc),
      .ctl_addr_sel(c_addr_sel), .ctl_ir_wr(c_ir_wr), .ctl_srca_sel(c_srca),
      .ctl_srcb_sel(c_srcb), .ctl_alu_op(c_op), .ctl_dst_sel(c_dst),
      .ctl_wb_sel(c_wb), .ctl_rf_wr(c_rf_wr), .ctl_mem_rd(c_mrd), .ctl_mem_wr(c_mwr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_opcode(opcode), .ir_funct(funct),
      .alu_zero(alu_zero)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Scoreboard
   typedef struct {
      int          cyc;
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic expect_at(input int sel, input logic [31:0] exp, input string tag);
      item_t it;
      it.cyc = cyc; it.sel = sel; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
   endtask

   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
         item_t it;
         logic [31:0] act;
         it = sbq.pop_front();
         case (it.sel)
            SEL_ADDR:  act = mem_addr;
            SEL_WDATA: act = mem_wdata;
            SEL_ZERO:  act = {31'b0, alu_zero};
            SEL_OPC:   act = {26'b0, opcode};
            default:   act = {26'b0, funct};
         endcase
         n_chk++;
         if (act !== it.exp || it.cyc != cyc) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", it.tag, act, it.exp, cyc);
         end
      end
   end

   // Reference state kept by the bench
   logic [31:0] rf_m [32];
   logic [31:0] exp_pc;

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] alu_ref(input int op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return ~(a | b);
         6: return {31'b0, $signed(a) < $signed(b)};
         default: return {31'b0, a < b};
      endcase
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rt, input int rs, input logic [15:0] imm);
      return {opc, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic idle();
      c_pc_wr = 0; c_pc_cond = 0; c_addr_sel = 0; c_ir_wr = 0; c_srca = 0;
      c_dst = 0; c_wb = 0; c_rf_wr = 0; c_mrd = 0; c_mwr = 0;
      c_srcb = 0; c_pcsrc = 0; c_op = 0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      idle();
   endtask

   task automatic set_rf(input int idx, input logic [31:0] v);
      if (idx != 0) rf_m[idx] = v;
   endtask

   // Fetch then decode; the decode cycle forms the branch target
   task automatic fetch_decode(input logic [31:0] word);
      ram[exp_pc[8:2]] = word;
      step();
      c_mrd = 1; c_ir_wr = 1; c_srcb = 2'd1; c_pc_wr = 1; c_pcsrc = 2'd0; c_op = 3'd0;
      expect_at(SEL_ADDR, exp_pc, "R9 R2 R1 fetch address from PC");
      exp_pc = exp_pc + 4;
      step();
      c_srcb = 2'd3;
      expect_at(SEL_OPC, {26'b0, word[31:26]}, "R8 opcode after fetch");
   endtask

   task automatic run_addi(input int rt, input int rs, input logic [15:0] imm);
      fetch_decode(enc_i(6'h08, rt, rs, imm));
      step(); c_srca = 1; c_srcb = 2'd2;
      step(); c_rf_wr = 1; c_dst = 0; c_wb = 0;
      set_rf(rt, rf_m[rs] + sext(imm));
   endtask

   task automatic run_r(input int op, input int rd, input int rs, input int rt);
      fetch_decode({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 3'b000, 3'(op)});
      expect_at(SEL_FUNCT, 32'(op), "R8 funct field");
      step(); c_srca = 1; c_srcb = 2'd0; c_op = 3'(op);
      step(); c_rf_wr = 1; c_dst = 1; c_wb = 0;
      set_rf(rd, alu_ref(op, rf_m[rs], rf_m[rt]));
   endtask

   task automatic run_lw(input int rt, input int rs, input logic [15:0] imm);
      logic [31:0] addr;
      fetch_decode(enc_i(6'h23, rt, rs, imm));
      addr = rf_m[rs] + sext(imm);
      step(); c_srca = 1; c_srcb = 2'd2;
      step(); c_addr_sel = 1; c_mrd = 1;
      expect_at(SEL_ADDR, addr, "R12 R1 load address from ALU result register");
      step(); c_rf_wr = 1; c_dst = 0; c_wb = 1;
      expect_at(SEL_OPC, 32'h23, "R8 instruction held during data read");
      set_rf(rt, ram[addr[8:2]]);
   endtask

   task automatic run_sw(input int rt, input int rs, input logic [15:0] imm, input string tag);
      logic [31:0] addr;
      fetch_decode(enc_i(6'h2B, rt, rs, imm));
      addr = rf_m[rs] + sext(imm);
      step(); c_srca = 1; c_srcb = 2'd2;
      step(); c_addr_sel = 1; c_mwr = 1;
      expect_at(SEL_ADDR, addr, "R12 R3 store address");
      expect_at(SEL_WDATA, rf_m[rt], tag);
      ram[addr[8:2]] = rf_m[rt];
   endtask

   task automatic run_beq(input int rs, input int rt, input logic [15:0] imm);
      logic [31:0] tgt;
      logic        eq;
      fetch_decode(enc_i(6'h04, rt, rs, imm));
      tgt = exp_pc + (sext(imm) << 2);
      eq  = (rf_m[rs] == rf_m[rt]);
      step(); c_srca = 1; c_srcb = 2'd0; c_op = 3'd1; c_pc_cond = 1; c_pcsrc = 2'd1;
      expect_at(SEL_ZERO, {31'b0, eq}, "R7 zero flag on compare");
      if (eq) exp_pc = tgt;
   endtask

   task automatic run_j(input logic [25:0] t26);
      fetch_decode({6'h02, t26});
      step(); c_pc_wr = 1; c_pcsrc = 2'd2;
      exp_pc = {exp_pc[31:28], t26, 2'b00};
   endtask

   task automatic do_reset(input string tag);
      step(); rst = 1;
      step();
      expect_at(SEL_ADDR, START, tag);
      step(); rst = 0;
      exp_pc = START;
      for (int i = 0; i < 32; i++) rf_m[i] = '0;
   endtask

   initial begin
      for (int i = 0; i < 128; i++) ram[i] = '0;
      ram[32'h1E0 >> 2] = 32'hDEAD_BEEF;
      idle();
      exp_pc = START;
      for (int i = 0; i < 32; i++) rf_m[i] = '0;

      do_reset("R10 PC start address after reset");
      run_sw(5, 0, 16'h01C0, "R10 register file cleared by reset");

      // Immediates, positive and negative
      run_addi(1, 0, 16'd5);
      run_addi(2, 0, 16'hFFFD);
      run_sw(1, 0, 16'h01C4, "R3 R5 positive immediate into rt");
      run_sw(2, 0, 16'h01C8, "R3 negative immediate sign-extended");

      // Every ALU operation, rd write index
      for (int op = 0; op < 8; op++) begin
         run_r(op, 3, 1, 2);
         run_sw(3, 0, 16'h01D0, $sformatf("R11 ALU op %0d result", op));
      end
      run_r(6, 3, 2, 1);
      run_sw(3, 0, 16'h01D0, "R11 signed less-than reversed operands");
      run_sw(2, 0, 16'h01D4, "R4 rt untouched by rd-indexed write");

      // Write index selection: immediate bits 15..11 point at r7
      run_addi(6, 0, 16'h3805);
      run_sw(6, 0, 16'h01D8, "R4 rt-indexed write lands in rt");
      run_sw(7, 0, 16'h01DC, "R4 bits 15..11 not used as index when select is 0");

      // Register 0
      run_addi(0, 0, 16'd9);
      run_sw(0, 0, 16'h01E4, "R6 register 0 after immediate write");
      run_r(0, 0, 1, 1);
      run_sw(0, 0, 16'h01E8, "R6 register 0 after ALU write");

      // Loads, positive and negative offset
      run_lw(4, 0, 16'h01E0);
      run_sw(4, 0, 16'h01EC, "R5 load data through memory data register");
      run_addi(10, 0, 16'h01E8);
      run_lw(9, 10, 16'hFFF8);
      run_sw(9, 0, 16'h01F0, "R5 R3 load with negative offset");

      // Branches
      run_beq(1, 2, 16'd5);
      run_sw(1, 0, 16'h01F4, "R7 untaken branch falls through");
      run_beq(1, 1, 16'd2);
      run_sw(1, 0, 16'h01F8, "R7 R9 taken branch reaches target");

      // Jump
      run_j(26'h0000040);
      run_sw(2, 0, 16'h01FC, "R9 execution continues at jump target");

      // Reset in mid-run
      do_reset("R10 PC restored by reset in mid-run");
      run_sw(1, 0, 16'h01C0, "R10 written register cleared by reset");

      step();
      step();
      step();
      if (sbq.size() != 0) begin
         n_bad += sbq.size();
         n_chk += sbq.size();
         $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule